// File: doc/BRIEF.md
# Indirect Register Access Port

This block puts a set of internal registers behind an 8-bit host bus that has only one address line. With the address line high, the host reaches the command port. With it low, the host reaches the data port. A command-port write loads either a bank pointer or a register pointer, depending on its top three bits. A command-port read returns a status byte directly, with no pointer setup.

Data-port accesses move byte by byte through the selected register, least significant byte first. Reads are served from a holding register that is loaded on the first byte, so a value that changes during the sequence is still read out coherently. Writes to a multi-byte register are staged, and the register changes only when its last byte arrives.

The host strobes are asynchronous and are synchronized into the core clock. An open-drain ready line is pulled low for a fixed number of clocks at the start of each access. An internal busy stub can hold the ready line low for longer, which adds wait states.

Top module: `idxreg_port`

## Requirements
- R1: A command-port write (`cd_i`=1) whose bits 7:5 are 000 loads the 5-bit bank pointer from bits 4:0 and restarts the byte sequence. A command byte whose bits 7:5 are neither 000 nor 111 changes nothing.
- R2: A command-port write whose bits 7:5 are 111 loads the 5-bit register pointer from bits 4:0 and restarts the byte sequence. The pointer that was not written keeps its previous value.
- R3: A command-port read returns the status byte. Bit 7 is `irq_act_i`, bit 6 is the sticky error flag, bit 5 is `match_i`, and bits 4:0 are 0.
- R4: The error flag is set by `err_set_i`. A status read clears it. When a set and a clear fall in the same cycle, the set wins.
- R5: Register map. Bank 0 register 0 is a 1-byte read/write register. Bank 0 register 3 is a 4-byte read/write register. Bank 0 register 9 is a 6-byte read/write register. Bank 1 register 0 is a 4-byte read-only image of `live_i`. The first data-port read after a restart copies the whole value into a holding register and returns byte 0. Each later read returns the next more significant byte of the held copy.
- R6: The data-port read after the last byte of a register wraps to byte 0 and takes a new snapshot.
- R7: A valid command write in the middle of a sequence aborts it. The next data access starts at byte 0.
- R8: A multi-byte register changes only on the write of its last byte. An aborted write sequence leaves the stored value unchanged.
- R9: Each access pulls `rdy_low_o` high (ready driven low) for exactly CYCLE_CLKS clocks from the synchronized strobe fall, then releases it. Read data is valid on `dq_o` at release.
- R10: While `busy_i` is high, an access in progress keeps `rdy_low_o` high.
- R11: `dq_oe_o` is high exactly when `cs_n_i` and `rd_n_i` are both low.
- R12: Data-port writes to read-only or unmapped registers are ignored and do not advance the byte sequence. Unmapped registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| cd_i | input | 1 | 1 = command port, 0 = data port |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| dq_i | input | 8 | Host write data |
| dq_o | output | 8 | Host read data |
| dq_oe_o | output | 1 | Drive enable for the data bus |
| rdy_low_o | output | 1 | 1 = pull the open-drain ready line low |
| busy_i | input | 1 | Stub that stalls ready |
| irq_act_i | input | 1 | Interrupt-active flag shown in status |
| match_i | input | 1 | Address-match flag shown in status |
| err_set_i | input | 1 | Sets the sticky error flag |
| live_i | input | 32 | Live value behind bank 1 register 0 |

## Verification
Two functions can act in the same cycle: the error-flag set from `err_set_i` and the clear caused by a status read. The bench provokes the collision by holding `err_set_i` high for the whole of a status-read transaction, so the clear lands on a cycle where the set is also active. The bench then requires the following status read to still show bit 6 set, and the read after that to show it cleared. Snapshot coherency is checked in a similar way: `live_i` is changed between byte reads, and the bytes that follow must still come from the old value.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;
  localparam int PTR_W = 5;
  localparam int MAXB  = 6;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    K_NONE, K_SCR, K_W32, K_W48, K_LIVE
  } reg_kind_e;

  function automatic reg_kind_e decode(input logic [PTR_W-1:0] b, input logic [PTR_W-1:0] r);
    if (b == 5'd0 && r == 5'd0) return K_SCR;
    if (b == 5'd0 && r == 5'd3) return K_W32;
    if (b == 5'd0 && r == 5'd9) return K_W48;
    if (b == 5'd1 && r == 5'd0) return K_LIVE;
    return K_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] kind_len(input reg_kind_e k);
    case (k)
      K_W32, K_LIVE: return 3'd4;
      K_W48:         return 3'd6;
      default:       return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/idxreg_sync.sv
module idxreg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end
  assign q_o = st[STAGES-1];
endmodule

// File: rtl/idxreg_ready.sv
module idxreg_ready #(
  parameter int CYCLE_CLKS = 10,
  localparam int CW = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  output logic drive_o
);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_o <= 1'b0;
      cnt     <= '0;
    end else if (start_i) begin
      drive_o <= 1'b1;
      cnt     <= CW'(CYCLE_CLKS - 1);
    end else if (drive_o) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else if (!busy_i) drive_o <= 1'b0;
    end
  end

  // R9: the ready line is not released before the count expires
  a_r9_hold_until_count: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && cnt != '0) |=> drive_o);
  // R10: busy keeps the ready line pulled low
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && busy_i) |=> drive_o);
endmodule

// File: rtl/idxreg_seq.sv
module idxreg_seq
  import idxreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr_i,
  input  logic        data_wr_i,
  input  logic        data_rd_i,
  input  logic        stat_rd_i,
  input  logic [7:0]  wbyte_i,
  input  logic [31:0] live_i,
  input  logic        irq_act_i,
  input  logic        match_i,
  input  logic        err_set_i,
  output logic [7:0]  rdata_o
);
  logic [PTR_W-1:0] bank, regp;
  logic [IDX_W-1:0] idx;
  logic [8*MAXB-1:0] hold, stage, nv, cur;
  logic [7:0]  scr;
  logic [31:0] w32;
  logic [47:0] w48;
  logic        err;
  reg_kind_e   kind;
  logic [IDX_W-1:0] len;
  logic        writable, last, valid_cmd;

  assign kind      = decode(bank, regp);
  assign len       = kind_len(kind);
  assign writable  = (kind == K_SCR) || (kind == K_W32) || (kind == K_W48);
  assign last      = (idx == len - 1'b1);
  assign valid_cmd = (wbyte_i[7:5] == 3'b000) || (wbyte_i[7:5] == 3'b111);

  always_comb begin
    case (kind)
      K_SCR:   cur = {40'd0, scr};
      K_W32:   cur = {16'd0, w32};
      K_W48:   cur = w48;
      K_LIVE:  cur = {16'd0, live_i};
      default: cur = '0;
    endcase
    nv = stage;
    nv[{idx, 3'b000} +: 8] = wbyte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0; regp <= '0; idx <= '0;
      hold <= '0; stage <= '0; scr <= '0; w32 <= '0; w48 <= '0;
      err <= 1'b0; rdata_o <= '0;
    end else begin
      if (err_set_i) err <= 1'b1;
      else if (stat_rd_i) err <= 1'b0;

      if (stat_rd_i) rdata_o <= {irq_act_i, err, match_i, 5'd0};

      if (cmd_wr_i && valid_cmd) begin
        if (wbyte_i[7:5] == 3'b000) bank <= wbyte_i[4:0];
        else regp <= wbyte_i[4:0];
        idx <= '0;
      end else if (data_rd_i) begin
        if (idx == '0) begin
          hold    <= cur;
          rdata_o <= cur[7:0];
        end else begin
          rdata_o <= hold[{idx, 3'b000} +: 8];
        end
        idx <= last ? '0 : idx + 1'b1;
      end else if (data_wr_i && writable) begin
        if (last) begin
          case (kind)
            K_SCR:   scr <= nv[7:0];
            K_W32:   w32 <= nv[31:0];
            default: w48 <= nv;
          endcase
          idx <= '0;
        end else begin
          stage <= nv;
          idx   <= idx + 1'b1;
        end
      end
    end
  end

  // R4: a set in the same cycle as a status read leaves the flag set
  a_r4_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_i |=> err);
  // R6: the byte index never leaves the selected register
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < len);
  // R7: a valid command write restarts the sequence
  a_r7_cmd_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && valid_cmd) |=> (idx == '0));
  // R8: the wide register is stable unless its last byte is written
  a_r8_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr_i && kind == K_W48 && last && !cmd_wr_i) |=> $stable(w48));
endmodule

// File: rtl/idxreg_port.sv
module idxreg_port #(
  parameter int CYCLE_CLKS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        cd_i,
  input  logic        rd_n_i,
  input  logic        wr_n_i,
  input  logic [7:0]  dq_i,
  output logic [7:0]  dq_o,
  output logic        dq_oe_o,
  output logic        rdy_low_o,
  input  logic        busy_i,
  input  logic        irq_act_i,
  input  logic        match_i,
  input  logic        err_set_i,
  input  logic [31:0] live_i
);
  localparam int SW = 12;
  logic [SW-1:0] raw, syn;
  logic cs_s, cd_s, rd_s, wr_s;
  logic [7:0] dq_s;
  logic rd_act, wr_act, rd_q, wr_q;
  logic rd_fall, wr_fall, wr_rise;

  assign raw = {cs_n_i, rd_n_i, wr_n_i, cd_i, dq_i};

  idxreg_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(12'hE00)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  assign {cs_s, rd_s, wr_s, cd_s, dq_s} = syn;
  assign rd_act = !cs_s && !rd_s;
  assign wr_act = !cs_s && !wr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_fall = rd_act && !rd_q;
  assign wr_fall = wr_act && !wr_q;
  assign wr_rise = !wr_act && wr_q;

  idxreg_ready #(.CYCLE_CLKS(CYCLE_CLKS)) u_ready (
    .clk(clk), .rst_n(rst_n), .start_i(rd_fall || wr_fall),
    .busy_i(busy_i), .drive_o(rdy_low_o));

  idxreg_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_i(wr_rise && cd_s), .data_wr_i(wr_rise && !cd_s),
    .data_rd_i(rd_fall && !cd_s), .stat_rd_i(rd_fall && cd_s),
    .wbyte_i(dq_s), .live_i(live_i), .irq_act_i(irq_act_i),
    .match_i(match_i), .err_set_i(err_set_i), .rdata_o(dq_o));

  assign dq_oe_o = !cs_n_i && !rd_n_i;

  // R9: every access start pulls the ready line low in the next cycle
  a_r9_start_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall || wr_fall) |=> rdy_low_o);
endmodule

// File: tb/idxreg_port_tb.sv
module idxreg_port_tb_top;
  localparam int CYC = 10;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, cd = 0, rd_n = 1, wr_n = 1, busy = 0, irq = 0, match = 0, err_set = 0;
  logic [7:0] dq_i = 0, dq_o;
  logic dq_oe, rdy_low;
  logic [31:0] live = 0;
  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_bank = 0, m_reg = 0, m_idx = 0;
  logic [47:0] m_hold = 0, m_stage = 0, m_w48 = 0;
  logic [31:0] m_w32 = 0;
  logic [7:0]  m_scr = 0;
  bit m_err = 0;

  always #2 clk = ~clk;

  idxreg_port #(.CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cd_i(cd), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe), .rdy_low_o(rdy_low), .busy_i(busy),
    .irq_act_i(irq), .match_i(match), .err_set_i(err_set), .live_i(live));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11 compared on every clock against the pins
  always @(negedge clk) if (rst_n && !done) chk("R11", dq_oe, (!cs_n && !rd_n));

  function automatic int mlen();
    if (m_bank == 0 && m_reg == 3) return 4;
    if (m_bank == 0 && m_reg == 9) return 6;
    if (m_bank == 1 && m_reg == 0) return 4;
    return 1;
  endfunction

  function automatic logic [47:0] mcur();
    if (m_bank == 0 && m_reg == 0) return {40'd0, m_scr};
    if (m_bank == 0 && m_reg == 3) return {16'd0, m_w32};
    if (m_bank == 0 && m_reg == 9) return m_w48;
    if (m_bank == 1 && m_reg == 0) return {16'd0, live};
    return 48'd0;
  endfunction

  task automatic bus(input bit is_wr, input bit c, input logic [7:0] b,
                     output logic [7:0] rb, output int lows);
    int t;
    lows = 0;
    @(negedge clk); cs_n = 0; cd = c; dq_i = b;
    @(negedge clk); if (is_wr) wr_n = 0; else rd_n = 0;
    t = 0;
    while (!rdy_low && t < 30) begin @(negedge clk); t++; end
    while (rdy_low && lows < 500) begin lows++; @(negedge clk); end
    rb = dq_o;
    if (is_wr) wr_n = 1; else rd_n = 1;
    @(negedge clk); cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    logic [7:0] rb; int l;
    bus(1, 1, b, rb, l);
    if (b[7:5] == 3'b000) begin m_bank = b[4:0]; m_idx = 0; end
    else if (b[7:5] == 3'b111) begin m_reg = b[4:0]; m_idx = 0; end
  endtask

  task automatic dwr(input logic [7:0] b);
    logic [7:0] rb; int l;
    bit wrt;
    bus(1, 0, b, rb, l);
    chk("R9 write ready", l, CYC);
    wrt = (m_bank == 0) && (m_reg == 0 || m_reg == 3 || m_reg == 9);
    if (wrt) begin
      m_stage[m_idx*8 +: 8] = b;
      if (m_idx == mlen() - 1) begin
        if (m_reg == 0) m_scr = m_stage[7:0];
        else if (m_reg == 3) m_w32 = m_stage[31:0];
        else m_w48 = m_stage;
        m_idx = 0;
      end else m_idx++;
    end
  endtask

  task automatic drd(input string req);
    logic [7:0] rb, e; int l;
    if (m_idx == 0) m_hold = mcur();
    e = m_hold[m_idx*8 +: 8];
    bus(0, 0, 8'h00, rb, l);
    chk(req, rb, e);
    chk("R9 read ready", l, CYC);
    m_idx = (m_idx == mlen() - 1) ? 0 : m_idx + 1;
  endtask

  task automatic srd(input string req);
    logic [7:0] rb; int l;
    bus(0, 1, 8'h00, rb, l);
    chk(req, rb, {irq, m_err, match, 5'd0});
    if (err_set) m_err = 1; else m_err = 0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb; int l;
    repeat (4) @(negedge clk);
    chk("R9 reset", rdy_low, 0);
    chk("R11 reset", dq_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R3 status fields, R4 err sticky/clear
    irq = 1; match = 0; srd("R3 status");
    @(negedge clk); err_set = 1; @(negedge clk); err_set = 0; m_err = 1;
    srd("R4 err set"); srd("R4 err cleared");
    match = 1; irq = 0; srd("R3 match");
    // R4 same-cycle collision: set held during a status read
    m_err = 1; err_set = 1; srd("R4 collide read"); err_set = 0;
    srd("R4 set wins"); srd("R4 cleared after");

    // R1 R2 R5 scratch register
    cmd(8'h00); cmd(8'hE0); dwr(8'h5A); drd("R5 scratch"); drd("R6 scratch repeat");
    // R8 4-byte write
    cmd(8'hE3); dwr(8'h11); dwr(8'h22); dwr(8'h33); dwr(8'h44);
    drd("R5 w32 b0"); drd("R5 w32 b1"); drd("R5 w32 b2"); drd("R5 w32 b3"); drd("R6 wrap");
    // R1 ignored prefix: pointer persists
    cmd(8'h45); drd("R1 ignored prefix");
    // R8 aborted 6-byte write, then full write
    cmd(8'hE9); dwr(8'hA1); dwr(8'hA2); dwr(8'hA3);
    cmd(8'hE9);
    for (int i = 0; i < 6; i++) drd("R8 abort keeps");
    for (int i = 0; i < 6; i++) dwr(8'hC0 + 8'(i));
    for (int i = 0; i < 6; i++) drd("R8 commit");
    // R5 snapshot on live value, R6 re-snapshot, R7 restart
    cmd(8'h01); cmd(8'hE0);
    live = 32'h11223344; drd("R5 snap b0");
    live = 32'hAABBCCDD; drd("R5 snap b1"); drd("R5 snap b2"); drd("R5 snap b3");
    drd("R6 resnap"); drd("R6 resnap b1");
    cmd(8'hE0); drd("R7 restart b0");
    // R12 write to read-only ignored, sequence not advanced
    dwr(8'h77); drd("R12 ro write ignored");
    // R12 unmapped read
    cmd(8'h02); cmd(8'hE5); drd("R12 unmapped"); dwr(8'h99); drd("R12 unmapped write");
    // R2 bank change keeps register pointer
    cmd(8'h00); cmd(8'hE3); cmd(8'h01); cmd(8'h00); drd("R2 reg ptr kept");

    // R10 busy stretches ready
    busy = 1;
    fork
      begin
        bus(0, 1, 8'h00, rb, l);
      end
      begin
        repeat (40) @(negedge clk);
        chk("R10 busy holds", rdy_low, 1);
        busy = 0;
      end
    join
    chk("R10 stretched", (l > 30), 1);
    m_err = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule